// File: doc/BRIEF.md
# Dual Sub-Channel Cache-Line Burst Engine

The engine accepts 64-byte cache-line reads and writes from a host and spreads them over two independent 32-bit memory sub-channels. Each request is steered by one address bit to a sub-channel, queued there, and then moved as a single 16-beat burst. Write lines are serialised into beats. Read beats are gathered back into a full line, which is returned with the requester's tag.

The two sub-channels share nothing but the host request port and the response port, so two lines can be in flight at once. When both finish together, a round-robin arbiter picks which one reports first. A side-band check byte travels with every beat. On writes it is generated. On reads it is compared, and any mismatch marks the response of that line as corrupt.

Top module: `line_burst_engine`

## Requirements
- R1: After a cycle with `rst` high, `req_ready` is 1, `rsp_valid` is 0, and neither sub-channel shows a command, a write beat or a pending burst.
- R2: A request whose address bit 6 is 0 goes to sub-channel 0, and one whose bit 6 is 1 goes to sub-channel 1. The command carries the full request address, and `rsp_sc` names the sub-channel that served the line.
- R3: A write issues one command cycle with `sc_cmd_write`=1. Starting the next cycle it drives 16 consecutive beats with `sc_wr_valid`=1, and beat k carries line bits [32k+31:32k].
- R4: A read issues one command cycle with `sc_cmd_write`=0. It then takes 16 beats qualified by `sc_rd_valid`, which may arrive with idle cycles between them, and beat k fills line bits [32k+31:32k]. The line is reported by a one-cycle `rsp_valid` with `rsp_write`=0 and the request's `req_id`.
- R5: On every write beat, `sc_wr_chk` equals the XOR of the four bytes of `sc_wr_data`.
- R6: A read beat whose `sc_rd_chk` differs from the XOR of its four data bytes sets `rsp_err` on that line's response only. Clean reads and all write responses report `rsp_err`=0.
- R7: Each sub-channel queues up to 4 requests in addition to the one it is moving. `req_ready` is low while the queue selected by `req_addr` bit 6 is full, and a request aimed at the other sub-channel is still accepted.
- R8: Each accepted request produces exactly one response. Writes respond with `rsp_write`=1. Responses from one sub-channel come back in acceptance order.
- R9: The two sub-channels can move bursts during the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Target queue can take the request |
| req_write | input | 1 | 1 = line write, 0 = line read |
| req_addr | input | 32 | Byte address of the line |
| req_id | input | 4 | Requester tag |
| req_wdata | input | 512 | Line to write |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_write | output | 1 | Completion is for a write |
| rsp_id | output | 4 | Tag of the completed request |
| rsp_data | output | 512 | Gathered line (reads only) |
| rsp_err | output | 1 | Check-byte mismatch on a read line |
| rsp_sc | output | 1 | Sub-channel that served the line |
| sc_cmd_valid | output | 2 | Per sub-channel command strobe |
| sc_cmd_write | output | 2 | Command direction |
| sc_cmd_addr | output | 2x32 | Command address |
| sc_wr_valid | output | 2 | Write beat present |
| sc_wr_data | output | 2x32 | Write beat data |
| sc_wr_chk | output | 2x8 | Write beat check byte |
| sc_rd_valid | input | 2 | Read beat present |
| sc_rd_data | input | 2x32 | Read beat data |
| sc_rd_chk | input | 2x8 | Read beat check byte |

## Verification
The assertions assume that a memory side returns exactly 16 read beats per read command and never raises `sc_rd_valid` without an outstanding read. They also assume the host holds a request stable until it is accepted. The bench follows these assumptions. Its memory models answer each command with one burst, and stalls are applied only before the first beat. The host task holds `req_valid` and the request fields until it sees `req_ready`. Deliberate check-byte corruption is applied only on read data, which is the one place the design compares it.

// File: rtl/lbe_pkg.sv
package lbe_pkg;
  localparam int NSC = 2;

  typedef enum logic [2:0] {
    SC_IDLE,
    SC_CMD,
    SC_WBURST,
    SC_RGATHER,
    SC_HOLD
  } sc_state_e;
endpackage

// File: rtl/lbe_req_fifo.sv
module lbe_req_fifo #(
  parameter int WIDTH = 549,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    level;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign dout  = store[rd_ptr];
  assign empty = (level == '0);
  assign full  = (level == CW'(DEPTH));
endmodule

// File: rtl/lbe_subchan.sv
module lbe_subchan import lbe_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int BEAT_W = 32,
  parameter int BEATS  = 16,
  parameter int CHK_W  = 8,
  parameter bit CHK_EN = 1'b1,
  localparam int LINE_W = BEAT_W * BEATS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              q_empty,
  input  logic              q_write,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic [ID_W-1:0]   q_id,
  input  logic [LINE_W-1:0] q_data,
  output logic              q_pop,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wr_valid,
  output logic [BEAT_W-1:0] wr_data,
  output logic [CHK_W-1:0]  wr_chk,
  input  logic              rd_valid,
  input  logic [BEAT_W-1:0] rd_data,
  input  logic [CHK_W-1:0]  rd_chk,
  output logic              done_valid,
  output logic              done_write,
  output logic [ID_W-1:0]   done_id,
  output logic [LINE_W-1:0] done_data,
  output logic              done_err,
  input  logic              done_take
);
  localparam int CNT_W  = $clog2(BEATS);
  localparam int FOLDS  = BEAT_W / CHK_W;

  sc_state_e         state;
  logic [CNT_W-1:0]  beat;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ID_W-1:0]   id_q;
  logic [LINE_W-1:0] line_q;
  logic              err_q;
  logic              rd_bad;
  logic              last_beat;

  function automatic logic [CHK_W-1:0] fold(input logic [BEAT_W-1:0] d);
    logic [CHK_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < FOLDS; k++) acc = acc ^ d[k*CHK_W +: CHK_W];
    return acc;
  endfunction

  generate
    if (CHK_EN) begin : g_chk
      assign wr_chk = fold(line_q[BEAT_W-1:0]);
      assign rd_bad = (fold(rd_data) != rd_chk);
    end else begin : g_nochk
      assign wr_chk = '0;
      assign rd_bad = 1'b0;
    end
  endgenerate

  assign last_beat = (beat == CNT_W'(BEATS - 1));
  assign q_pop     = (state == SC_IDLE) && !q_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SC_IDLE;
      beat    <= '0;
      write_q <= 1'b0;
      addr_q  <= '0;
      id_q    <= '0;
      line_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state)
        SC_IDLE: begin
          if (!q_empty) begin
            state   <= SC_CMD;
            write_q <= q_write;
            addr_q  <= q_addr;
            id_q    <= q_id;
            line_q  <= q_write ? q_data : '0;
            err_q   <= 1'b0;
            beat    <= '0;
          end
        end
        SC_CMD: state <= write_q ? SC_WBURST : SC_RGATHER;
        SC_WBURST: begin
          line_q <= {{BEAT_W{1'b0}}, line_q[LINE_W-1:BEAT_W]};
          beat   <= beat + 1'b1;
          if (last_beat) state <= SC_HOLD;
        end
        SC_RGATHER: begin
          if (rd_valid) begin
            line_q <= {rd_data, line_q[LINE_W-1:BEAT_W]};
            err_q  <= err_q | rd_bad;
            beat   <= beat + 1'b1;
            if (last_beat) state <= SC_HOLD;
          end
        end
        SC_HOLD: if (done_take) state <= SC_IDLE;
        default: state <= SC_IDLE;
      endcase
    end
  end

  assign cmd_valid  = (state == SC_CMD);
  assign cmd_write  = write_q;
  assign cmd_addr   = addr_q;
  assign wr_valid   = (state == SC_WBURST);
  assign wr_data    = line_q[BEAT_W-1:0];
  assign done_valid = (state == SC_HOLD);
  assign done_write = write_q;
  assign done_id    = id_q;
  assign done_data  = line_q;
  assign done_err   = err_q;
endmodule

// File: rtl/lbe_rsp_arb.sv
module lbe_rsp_arb import lbe_pkg::*; #(
  parameter int ID_W   = 4,
  parameter int LINE_W = 512
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NSC-1:0]              done_valid,
  input  logic [NSC-1:0]              done_write,
  input  logic [NSC-1:0][ID_W-1:0]    done_id,
  input  logic [NSC-1:0][LINE_W-1:0]  done_data,
  input  logic [NSC-1:0]              done_err,
  output logic [NSC-1:0]              done_take,
  output logic                        rsp_valid,
  output logic                        rsp_write,
  output logic [ID_W-1:0]             rsp_id,
  output logic [LINE_W-1:0]           rsp_data,
  output logic                        rsp_err,
  output logic                        rsp_sc
);
  logic last_q;
  logic sel;
  logic any;

  assign any = |done_valid;
  // both waiting: serve the one that was not served last
  assign sel = (done_valid == 2'b11) ? ~last_q : done_valid[1];

  always_comb begin
    done_take = '0;
    if (any) done_take[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_write <= 1'b0;
      rsp_id    <= '0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      rsp_sc    <= 1'b0;
    end else begin
      rsp_valid <= any;
      if (any) begin
        last_q    <= sel;
        rsp_write <= done_write[sel];
        rsp_id    <= done_id[sel];
        rsp_data  <= done_data[sel];
        rsp_err   <= done_err[sel];
        rsp_sc    <= sel;
      end
    end
  end
endmodule

// File: rtl/line_burst_engine.sv
module line_burst_engine import lbe_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int ID_W       = 4,
  parameter int BEAT_W     = 32,
  parameter int BEATS      = 16,
  parameter int CHK_W      = 8,
  parameter bit CHK_EN     = 1'b1,
  parameter int FIFO_DEPTH = 4,
  parameter int SEL_BIT    = 6,
  localparam int LINE_W    = BEAT_W * BEATS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [ID_W-1:0]            req_id,
  input  logic [LINE_W-1:0]          req_wdata,
  output logic                       rsp_valid,
  output logic                       rsp_write,
  output logic [ID_W-1:0]            rsp_id,
  output logic [LINE_W-1:0]          rsp_data,
  output logic                       rsp_err,
  output logic                       rsp_sc,
  output logic [1:0]                 sc_cmd_valid,
  output logic [1:0]                 sc_cmd_write,
  output logic [1:0][ADDR_W-1:0]     sc_cmd_addr,
  output logic [1:0]                 sc_wr_valid,
  output logic [1:0][BEAT_W-1:0]     sc_wr_data,
  output logic [1:0][CHK_W-1:0]      sc_wr_chk,
  input  logic [1:0]                 sc_rd_valid,
  input  logic [1:0][BEAT_W-1:0]     sc_rd_data,
  input  logic [1:0][CHK_W-1:0]      sc_rd_chk
);
  localparam int ENT_W = 1 + ADDR_W + ID_W + LINE_W;

  logic                       tgt;
  logic [NSC-1:0]             q_full, q_empty, q_push, q_pop;
  logic [NSC-1:0][ENT_W-1:0]  q_dout;
  logic [NSC-1:0]             d_valid, d_write, d_err, d_take;
  logic [NSC-1:0][ID_W-1:0]   d_id;
  logic [NSC-1:0][LINE_W-1:0] d_data;
  logic [ENT_W-1:0]           entry;

  assign tgt       = req_addr[SEL_BIT];
  assign req_ready = !q_full[tgt];
  assign entry     = {req_write, req_addr, req_id, req_wdata};

  for (genvar i = 0; i < NSC; i++) begin : g_sc
    assign q_push[i] = req_valid && req_ready && (tgt == 1'(i));

    lbe_req_fifo #(.WIDTH(ENT_W), .DEPTH(FIFO_DEPTH)) u_q (
      .clk   (clk),
      .rst   (rst),
      .push  (q_push[i]),
      .din   (entry),
      .pop   (q_pop[i]),
      .dout  (q_dout[i]),
      .empty (q_empty[i]),
      .full  (q_full[i])
    );

    lbe_subchan #(
      .ADDR_W(ADDR_W), .ID_W(ID_W), .BEAT_W(BEAT_W),
      .BEATS(BEATS), .CHK_W(CHK_W), .CHK_EN(CHK_EN)
    ) u_eng (
      .clk        (clk),
      .rst        (rst),
      .q_empty    (q_empty[i]),
      .q_write    (q_dout[i][ENT_W-1]),
      .q_addr     (q_dout[i][ID_W+LINE_W +: ADDR_W]),
      .q_id       (q_dout[i][LINE_W +: ID_W]),
      .q_data     (q_dout[i][LINE_W-1:0]),
      .q_pop      (q_pop[i]),
      .cmd_valid  (sc_cmd_valid[i]),
      .cmd_write  (sc_cmd_write[i]),
      .cmd_addr   (sc_cmd_addr[i]),
      .wr_valid   (sc_wr_valid[i]),
      .wr_data    (sc_wr_data[i]),
      .wr_chk     (sc_wr_chk[i]),
      .rd_valid   (sc_rd_valid[i]),
      .rd_data    (sc_rd_data[i]),
      .rd_chk     (sc_rd_chk[i]),
      .done_valid (d_valid[i]),
      .done_write (d_write[i]),
      .done_id    (d_id[i]),
      .done_data  (d_data[i]),
      .done_err   (d_err[i]),
      .done_take  (d_take[i])
    );
  end

  lbe_rsp_arb #(.ID_W(ID_W), .LINE_W(LINE_W)) u_arb (
    .clk        (clk),
    .rst        (rst),
    .done_valid (d_valid),
    .done_write (d_write),
    .done_id    (d_id),
    .done_data  (d_data),
    .done_err   (d_err),
    .done_take  (d_take),
    .rsp_valid  (rsp_valid),
    .rsp_write  (rsp_write),
    .rsp_id     (rsp_id),
    .rsp_data   (rsp_data),
    .rsp_err    (rsp_err),
    .rsp_sc     (rsp_sc)
  );
endmodule

// File: rtl/lbe_checker.sv
module lbe_checker #(
  parameter int ADDR_W     = 32,
  parameter int BEATS      = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int SEL_BIT    = 6
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [ADDR_W-1:0]      req_addr,
  input logic                   rsp_valid,
  input logic                   rsp_write,
  input logic                   rsp_err,
  input logic                   rsp_sc,
  input logic [1:0]             sc_cmd_valid,
  input logic [1:0][ADDR_W-1:0] sc_cmd_addr,
  input logic [1:0]             sc_wr_valid
);
  localparam int MAX_OUT = FIFO_DEPTH + 1;

  logic [7:0] wcnt  [2];
  logic [7:0] outst [2];

  for (genvar i = 0; i < 2; i++) begin : g_mon
    always_ff @(posedge clk) begin
      if (rst) begin
        wcnt[i]  <= '0;
        outst[i] <= '0;
      end else begin
        if (sc_wr_valid[i])
          wcnt[i] <= (int'(wcnt[i]) == BEATS - 1) ? 8'd0 : wcnt[i] + 8'd1;
        outst[i] <= outst[i]
                  + 8'(req_valid && req_ready && (req_addr[SEL_BIT] == 1'(i)))
                  - 8'(rsp_valid && (rsp_sc == 1'(i)));
      end
    end

    // R2: command address bit matches the serving sub-channel
    a_r2_steer: assert property (@(posedge clk) disable iff (rst)
      sc_cmd_valid[i] |-> (sc_cmd_addr[i][SEL_BIT] == 1'(i)));

    // R3: a new command only once the previous write burst is complete
    a_r3_whole_burst: assert property (@(posedge clk) disable iff (rst)
      sc_cmd_valid[i] |-> (wcnt[i] == 8'd0));

    // R3: a write burst starts right after its command cycle
    a_r3_cmd_leads: assert property (@(posedge clk) disable iff (rst)
      $rose(sc_wr_valid[i]) |-> $past(sc_cmd_valid[i]));

    // R7: never more lines held for one sub-channel than queue plus engine
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
      int'(outst[i]) <= MAX_OUT);
  end

  // R1: reset leaves the response port and both sub-channels quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rsp_valid && (sc_cmd_valid == 2'b00) && (sc_wr_valid == 2'b00)));

  // R6: write completions never carry the error flag
  a_r6_write_clean: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_write) |-> !rsp_err);
endmodule

bind line_burst_engine lbe_checker #(
  .ADDR_W(ADDR_W), .BEATS(BEATS), .FIFO_DEPTH(FIFO_DEPTH), .SEL_BIT(SEL_BIT)
) u_chk (.*);

// File: tb/sim_line_burst_engine.sv
`timescale 1ns/1ps
module sim_line_burst_engine;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic               req_write = 1'b0;
  logic [31:0]        req_addr = '0;
  logic [3:0]         req_id = '0;
  logic [511:0]       req_wdata = '0;
  logic               rsp_valid, rsp_write, rsp_err, rsp_sc;
  logic [3:0]         rsp_id;
  logic [511:0]       rsp_data;
  logic [1:0]         sc_cmd_valid, sc_cmd_write, sc_wr_valid, sc_rd_valid;
  logic [1:0][31:0]   sc_cmd_addr, sc_wr_data, sc_rd_data;
  logic [1:0][7:0]    sc_wr_chk, sc_rd_chk;

  int n_chk = 0, n_fail = 0;
  logic stall [2];
  logic gap   [2];
  logic bad   [2];
  logic both_wr = 1'b0, both_rd = 1'b0;

  logic         r_write [64];
  logic [3:0]   r_id    [64];
  logic [511:0] r_data  [64];
  logic         r_err   [64];
  logic         r_sc    [64];
  int           rcnt = 0;

  always #4 clk = ~clk;

  line_burst_engine u0 (.*);

  function automatic logic [7:0] bfold(input logic [31:0] d);
    return d[7:0] ^ d[15:8] ^ d[23:16] ^ d[31:24];
  endfunction

  function automatic logic [511:0] mk_line(input int seed);
    logic [511:0] l;
    for (int b = 0; b < 16; b++)
      l[b*32 +: 32] = (32'(seed) << 20) ^ (32'(b) * 32'h0101_0101) ^ 32'h5A00_00C3;
    return l;
  endfunction

  // memory models, one per sub-channel, driven away from the active edge
  for (genvar g = 0; g < 2; g++) begin : g_mem
    logic [31:0] mem [16][16];
    logic        v = 1'b0;
    logic [31:0] d = '0;
    logic [7:0]  k = '0;
    int          cmds = 0;
    int          wr_bad = 0;
    logic [31:0] last_addr = '0;
    assign sc_rd_valid[g] = v;
    assign sc_rd_data[g]  = d;
    assign sc_rd_chk[g]   = k;

    initial begin
      for (int i = 0; i < 16; i++)
        for (int b = 0; b < 16; b++) mem[i][b] = '0;
      forever begin
        @(negedge clk);
        if (!rst && sc_cmd_valid[g]) begin
          int idx;
          cmds++;
          last_addr = sc_cmd_addr[g];
          idx = int'(sc_cmd_addr[g][10:7]);
          if (sc_cmd_write[g]) begin
            for (int b = 0; b < 16; b++) begin
              @(negedge clk);
              if (!sc_wr_valid[g] || sc_wr_chk[g] != bfold(sc_wr_data[g])) wr_bad++;
              mem[idx][b] = sc_wr_data[g];
            end
          end else begin
            while (stall[g]) @(negedge clk);
            for (int b = 0; b < 16; b++) begin
              @(negedge clk);
              if (gap[g] && b[0]) begin
                v = 1'b0;
                @(negedge clk);
              end
              v = 1'b1;
              d = mem[idx][b];
              k = bfold(mem[idx][b]) ^ ((bad[g] && b == 5) ? 8'h10 : 8'h00);
            end
            @(negedge clk);
            v = 1'b0;
          end
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (sc_wr_valid == 2'b11) both_wr = 1'b1;
      if (sc_rd_valid == 2'b11) both_rd = 1'b1;
      if (rsp_valid && rcnt < 64) begin
        r_write[rcnt] = rsp_write;
        r_id[rcnt]    = rsp_id;
        r_data[rcnt]  = rsp_data;
        r_err[rcnt]   = rsp_err;
        r_sc[rcnt]    = rsp_sc;
        rcnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [511:0] act,
                       input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input bit wr, input logic [31:0] a, input logic [3:0] id,
                      input logic [511:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_id = id; req_wdata = data;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(input int n);
    int t = 0;
    while (rcnt < n && t < 2000) begin @(negedge clk); t++; end
  endtask

  function automatic logic [511:0] stored(input int c, input int idx);
    logic [511:0] l;
    for (int b = 0; b < 16; b++)
      l[b*32 +: 32] = (c == 0) ? g_mem[0].mem[idx][b] : g_mem[1].mem[idx][b];
    return l;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready", 512'(req_ready), 512'(1));
    check(rsp_valid == 1'b0, "R1 rsp_valid", 512'(rsp_valid), 512'(0));
    check(sc_cmd_valid == 2'b00 && sc_wr_valid == 2'b00, "R1 sub-channels idle",
          512'({sc_cmd_valid, sc_wr_valid}), 512'(0));
  endtask

  task automatic t_write_steer();
    int base = rcnt;
    send(1'b1, 32'h0000_0000, 4'd1, mk_line(1));
    send(1'b1, 32'h0000_0040, 4'd2, mk_line(2));
    wait_rsp(base + 2);
    check(g_mem[0].cmds == 1 && g_mem[0].last_addr == 32'h0, "R2 bit6=0 to sub-channel 0",
          512'(g_mem[0].last_addr), 512'(0));
    check(g_mem[1].cmds == 1 && g_mem[1].last_addr == 32'h40, "R2 bit6=1 to sub-channel 1",
          512'(g_mem[1].last_addr), 512'(32'h40));
    check(stored(0, 0) == mk_line(1), "R3 beat order sub-channel 0", stored(0, 0), mk_line(1));
    check(stored(1, 0) == mk_line(2), "R3 beat order sub-channel 1", stored(1, 0), mk_line(2));
    check(g_mem[0].wr_bad == 0 && g_mem[1].wr_bad == 0, "R5 write check bytes",
          512'(g_mem[0].wr_bad + g_mem[1].wr_bad), 512'(0));
    check(rcnt == base + 2 && r_write[base] && r_write[base+1] && !r_err[base] && !r_err[base+1],
          "R8 write completions", 512'(rcnt - base), 512'(2));
    check(r_sc[base] != r_sc[base+1] && r_id[base] == (r_sc[base] ? 4'd2 : 4'd1),
          "R2 rsp_sc names sub-channel", 512'({r_sc[base], r_id[base]}), 512'(1));
    check(both_wr, "R9 concurrent write bursts", 512'(both_wr), 512'(1));
  endtask

  task automatic t_read_back();
    int base = rcnt;
    send(1'b0, 32'h0000_0000, 4'd5, '0);
    send(1'b0, 32'h0000_0040, 4'd6, '0);
    wait_rsp(base + 2);
    for (int j = 0; j < 2; j++) begin
      logic [511:0] e;
      e = (r_id[base+j] == 4'd5) ? mk_line(1) : mk_line(2);
      check(rcnt >= base + 2 && !r_write[base+j] && r_data[base+j] == e && !r_err[base+j],
            "R4 read line gathered with id", r_data[base+j], e);
    end
    check(both_rd, "R9 concurrent read bursts", 512'(both_rd), 512'(1));
  endtask

  task automatic t_order();
    int base = rcnt;
    bit ok = 1'b1;
    gap[0] = 1'b1;
    for (int i = 1; i <= 3; i++) send(1'b1, 32'(i) << 7, 4'(6 + i), mk_line(10 + i));
    for (int i = 1; i <= 3; i++) send(1'b0, 32'(i) << 7, 4'(9 + i), '0);
    wait_rsp(base + 6);
    for (int j = 0; j < 6; j++) if (r_id[base+j] != 4'(7 + j)) ok = 1'b0;
    check(ok && rcnt == base + 6, "R8 issue order on sub-channel 0",
          512'(r_id[base+5]), 512'(12));
    for (int j = 0; j < 3; j++)
      check(r_data[base+3+j] == mk_line(11 + j), "R4 gapped read data",
            r_data[base+3+j], mk_line(11 + j));
    gap[0] = 1'b0;
  endtask

  task automatic t_chk_err();
    int base = rcnt;
    bad[1] = 1'b1;
    send(1'b0, 32'h0000_0040, 4'd3, '0);
    wait_rsp(base + 1);
    bad[1] = 1'b0;
    send(1'b0, 32'h0000_0040, 4'd4, '0);
    wait_rsp(base + 2);
    check(r_err[base] == 1'b1, "R6 corrupted check byte flagged", 512'(r_err[base]), 512'(1));
    check(r_err[base+1] == 1'b0 && r_data[base+1] == mk_line(2), "R6 clean line unflagged",
          512'(r_err[base+1]), 512'(0));
  endtask

  task automatic t_full();
    int base = rcnt;
    bit ok = 1'b1;
    stall[0] = 1'b1;
    for (int i = 0; i < 5; i++) send(1'b0, 32'(i) << 7, 4'(i), '0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_0300; req_id = 4'd9;
    #1;
    check(req_ready == 1'b0, "R7 ready low with queue full", 512'(req_ready), 512'(0));
    req_addr = 32'h0000_0340;
    #1;
    check(req_ready == 1'b1, "R7 other sub-channel still ready", 512'(req_ready), 512'(1));
    req_valid = 1'b0;
    @(negedge clk);
    stall[0] = 1'b0;
    wait_rsp(base + 5);
    for (int j = 0; j < 5; j++) if (r_id[base+j] != 4'(j) || r_sc[base+j]) ok = 1'b0;
    check(ok && rcnt == base + 5, "R8 queued reads complete in order", 512'(rcnt - base), 512'(5));
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin stall[c] = 1'b0; gap[c] = 1'b0; bad[c] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_steer();
    t_read_back();
    t_order();
    t_chk_err();
    t_full();
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule